// File: doc/BRIEF.md
# Channel Data Word with Transfer-Clock Divider

This block holds the 16-bit data word of one serial channel. Its lower nine bits form the buffer between the bus and the channel's shift logic. Receive data from the shift register is loaded into it, and transmit data is tapped from it. Its upper seven bits hold a divider setting. The setting turns the operating clock into a transfer-clock enable pulse that the channel's framing logic uses to pace its bit timing.

The bus reads and writes the word through a port with one enable per byte. How a write lands depends on whether the channel is running. While it runs, only the data field can be written, and the divider field reads as zero. While it is stopped, the whole word is accessible. A write that enables only the lowest byte also wipes the divider field. A clock-select input replaces the divided pulse with the synchronised rising edges of an external serial clock. A configuration-error output flags a divider too small for asynchronous framing.

Top module: `xfer_word_reg`

## Requirements
- R1: After reset, the bus read value is 0000h, and both `xfer_tick` and `cfg_err` are low.
- R2: While `chan_en` is 0, a write with `bus_be` = 2'b11 stores all 16 bits. A write with `bus_be` = 2'b10 stores bits 15:8 only. Reads return the stored word.
- R3: While `chan_en` is 1, a write changes only bits 8:0. Bits 15:9 keep their value and read as 0, and they read back unchanged once `chan_en` returns to 0.
- R4: While `chan_en` is 0, a write with `bus_be` = 2'b01 stores bits 7:0, keeps bit 8 and clears bits 15:9 to 0.
- R5: `rx_load` stores `rx_data` into bits 8:0 on the next clock edge. On those bits it overrides a bus write in the same cycle. `tx_data` always shows bits 8:0.
- R6: With `ext_clk_sel` = 0 and bits 15:9 = N, `xfer_tick` is a one-cycle pulse repeating every 2*(N+1) clock cycles. The first pulse comes in the cycle after the 2N+1-th rising edge with `chan_en` high.
- R7: Dropping `chan_en` for one cycle and raising it again restarts the divider phase, so the first pulse again comes after 2N+1 edges.
- R8: With `ext_clk_sel` = 1, each rising edge of `ext_sclk` gives exactly one `xfer_tick` pulse, two clock edges after the input rises, and the divider produces none.
- R9: `cfg_err` is 1 exactly when `chan_en` = 1, `uart_mode` = 1, `ext_clk_sel` = 0 and bits 15:9 are 0 or 1.
- R10: `xfer_tick` stays low while `chan_en` is 0, whatever the clock source.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Operating clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_be | input | 2 | Byte enables, bit 0 = bits 7:0 |
| bus_wdata | input | 16 | Bus write data |
| bus_rdata | output | 16 | Bus read data |
| chan_en | input | 1 | Channel running |
| ext_clk_sel | input | 1 | 1 = external serial clock paces transfers |
| uart_mode | input | 1 | 1 = channel framed as asynchronous serial |
| ext_sclk | input | 1 | External serial clock, asynchronous |
| rx_load | input | 1 | Load strobe from receive shift register |
| rx_data | input | 9 | Parallel receive data |
| tx_data | output | 9 | Data field for the transmit shift register |
| xfer_tick | output | 1 | One-cycle transfer-clock enable |
| cfg_err | output | 1 | Illegal divider for asynchronous framing |

## Verification
The receive load and a bus write can fall in the same cycle, and both target the data field. The bench drives both strobes together on one edge while the channel runs, with different values on `rx_data` and `bus_wdata`. It then reads the word and the transmit tap and expects the receive value. After the channel stops, it reads the divider field to confirm that the concurrent bus write left it untouched.

// File: rtl/xwr_pkg.sv
package xwr_pkg;
   // Smallest divider setting accepted when the channel frames asynchronously.
   localparam int unsigned UART_MIN_DIV = 2;
   // Byte lanes on the bus side.
   localparam int unsigned LANE_W = 8;

   // Lane count for a word of the given width.
   function automatic int unsigned lanes_for(input int unsigned w);
      return (w + LANE_W - 1) / LANE_W;
   endfunction
endpackage

// File: rtl/xwr_store.sv
module xwr_store
   import xwr_pkg::*;
#(
   parameter int unsigned DATA_W = 9,
   parameter int unsigned DIV_W  = 7,
   localparam int unsigned WORD_W = DATA_W + DIV_W,
   localparam int unsigned NBE    = lanes_for(WORD_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chan_en,
   input  logic              bus_wr,
   input  logic [NBE-1:0]    bus_be,
   input  logic [WORD_W-1:0] bus_wdata,
   input  logic              rx_load,
   input  logic [DATA_W-1:0] rx_data,
   output logic [DATA_W-1:0] data_q,
   output logic [DIV_W-1:0]  div_q
);
   logic [WORD_W-1:0] bit_we;
   logic [WORD_W-1:0] word_q;
   logic [WORD_W-1:0] word_d;
   logic              low_only;

   // Spread lane enables to bit enables.
   for (genvar b = 0; b < WORD_W; b++) begin : g_bit_we
      assign bit_we[b] = bus_be[b / LANE_W];
   end

   assign low_only = bus_be[0] && (bus_be[NBE-1:1] == '0);

   always_comb begin
      word_d = word_q;
      if (bus_wr) begin
         for (int i = 0; i < WORD_W; i++) begin
            if (bit_we[i] && (!chan_en || (i < DATA_W)))
               word_d[i] = bus_wdata[i];
         end
         // Stopped lowest-lane-only write wipes the divider field.
         if (!chan_en && low_only) begin
            for (int i = DATA_W; i < WORD_W; i++) begin
               if (!bit_we[i])
                  word_d[i] = 1'b0;
            end
         end
      end
      // Receive load wins over any bus write on the data field.
      if (rx_load)
         word_d[DATA_W-1:0] = rx_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q <= '0;
      else        word_q <= word_d;
   end

   assign data_q = word_q[DATA_W-1:0];
   assign div_q  = word_q[WORD_W-1:DATA_W];
endmodule

// File: rtl/xwr_divider.sv
module xwr_divider #(
   parameter int unsigned DIV_W = 7,
   localparam int unsigned CNT_W = DIV_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div_n,
   output logic             tick
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last;

   // Period 2*(N+1) means terminal count 2N+1.
   assign last = {div_n, 1'b1};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (!run)           cnt_q <= '0;
      else if (cnt_q >= last)  cnt_q <= '0;
      else                     cnt_q <= cnt_q + 1'b1;
   end

   assign tick = run && (cnt_q == last);
endmodule

// File: rtl/xwr_edge_sync.sv
module xwr_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise
);
   logic [STAGES:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q[0] <= 1'b0;
      else        sh_q[0] <= async_in;
   end

   for (genvar s = 1; s <= STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh_q[s] <= 1'b0;
         else        sh_q[s] <= sh_q[s-1];
      end
   end

   assign rise = sh_q[STAGES-1] && !sh_q[STAGES];
endmodule

// File: rtl/xfer_word_reg.sv
module xfer_word_reg
   import xwr_pkg::*;
#(
   parameter int unsigned DATA_W      = 9,
   parameter int unsigned DIV_W       = 7,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned WORD_W = DATA_W + DIV_W,
   localparam int unsigned NBE    = lanes_for(WORD_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [NBE-1:0]    bus_be,
   input  logic [WORD_W-1:0] bus_wdata,
   output logic [WORD_W-1:0] bus_rdata,
   input  logic              chan_en,
   input  logic              ext_clk_sel,
   input  logic              uart_mode,
   input  logic              ext_sclk,
   input  logic              rx_load,
   input  logic [DATA_W-1:0] rx_data,
   output logic [DATA_W-1:0] tx_data,
   output logic              xfer_tick,
   output logic              cfg_err
);
   localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(UART_MIN_DIV);

   // Elaboration-time parameter checks.
   if (DATA_W <= LANE_W) begin : g_bad_data
      $error("DATA_W must exceed one byte lane");
   end
   if (DIV_W < 2) begin : g_bad_div
      $error("DIV_W must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [DATA_W-1:0] data_q;
   logic [DIV_W-1:0]  div_q;
   logic              div_tick;
   logic              ext_rise;

   xwr_store #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .chan_en   (chan_en),
      .bus_wr    (bus_wr),
      .bus_be    (bus_be),
      .bus_wdata (bus_wdata),
      .rx_load   (rx_load),
      .rx_data   (rx_data),
      .data_q    (data_q),
      .div_q     (div_q)
   );

   xwr_divider #(.DIV_W(DIV_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (chan_en && !ext_clk_sel),
      .div_n (div_q),
      .tick  (div_tick)
   );

   xwr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (ext_sclk),
      .rise     (ext_rise)
   );

   assign bus_rdata = {(chan_en ? '0 : div_q), data_q};
   assign tx_data   = data_q;
   assign xfer_tick = ext_clk_sel ? (chan_en && ext_rise) : div_tick;
   assign cfg_err   = chan_en && uart_mode && !ext_clk_sel && (div_q < MIN_DIV);
endmodule

// File: rtl/xwr_checker.sv
module xwr_checker #(
   parameter int unsigned DATA_W = 9,
   parameter int unsigned DIV_W  = 7,
   parameter int unsigned NBE    = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [NBE-1:0]    bus_be,
   input logic              chan_en,
   input logic              ext_clk_sel,
   input logic              uart_mode,
   input logic              rx_load,
   input logic [DATA_W-1:0] rx_data,
   input logic [DATA_W-1:0] tx_data,
   input logic [DIV_W-1:0]  div_q,
   input logic              xfer_tick,
   input logic              cfg_err
);
   a_r3_div_frozen_when_running: assert property (@(posedge clk) disable iff (!rst_n)
      $past(chan_en) |-> (div_q == $past(div_q)));

   a_r4_low_lane_clears_div: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !chan_en && (bus_be == NBE'(1))) |=> (div_q == '0));

   a_r5_rx_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
      rx_load |=> (tx_data == $past(rx_data)));

   a_r6_div_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
      (!ext_clk_sel && xfer_tick) |=> (!xfer_tick || ext_clk_sel));

   a_r8_ext_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_clk_sel && xfer_tick) |=> (!xfer_tick || !ext_clk_sel));

   a_r9_cfg_err_context: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> (chan_en && uart_mode && !ext_clk_sel));

   a_r10_quiet_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      !chan_en |-> !xfer_tick);
endmodule

bind xfer_word_reg xwr_checker #(.DATA_W(DATA_W), .DIV_W(DIV_W), .NBE(NBE)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_wr      (bus_wr),
   .bus_be      (bus_be),
   .chan_en     (chan_en),
   .ext_clk_sel (ext_clk_sel),
   .uart_mode   (uart_mode),
   .rx_load     (rx_load),
   .rx_data     (rx_data),
   .tx_data     (tx_data),
   .div_q       (div_q),
   .xfer_tick   (xfer_tick),
   .cfg_err     (cfg_err)
);

// File: tb/xfer_word_reg_tb_top.sv
module xfer_word_reg_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [1:0]  bus_be = 2'b00;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        chan_en = 1'b0;
   logic        ext_clk_sel = 1'b0;
   logic        uart_mode = 1'b0;
   logic        ext_sclk = 1'b0;
   logic        rx_load = 1'b0;
   logic [8:0]  rx_data = '0;
   logic [8:0]  tx_data;
   logic        xfer_tick;
   logic        cfg_err;

   int n_checks = 0;
   int n_errs   = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;

   xfer_word_reg dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_be(bus_be),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .chan_en(chan_en),
      .ext_clk_sel(ext_clk_sel), .uart_mode(uart_mode), .ext_sclk(ext_sclk),
      .rx_load(rx_load), .rx_data(rx_data), .tx_data(tx_data),
      .xfer_tick(xfer_tick), .cfg_err(cfg_err)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errs++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [1:0] be, input logic [15:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_be = be; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_be = 2'b00;
   endtask

   task automatic t_reset();
      chk("R1 rdata", bus_rdata, 16'h0000);
      chk("R1 tick", xfer_tick, 0);
      chk("R1 cfg_err", cfg_err, 0);
   endtask

   task automatic t_full_write();
      chan_en = 1'b0;
      bus_write(2'b11, 16'hC3A5);
      chk("R2 full write", bus_rdata, 16'hC3A5);
      bus_write(2'b10, 16'h5A00);
      chk("R2 high lane write", bus_rdata, 16'h5AA5);
   endtask

   task automatic t_enabled_write();
      bus_write(2'b11, 16'hFE5A);
      @(negedge clk); chan_en = 1'b1;
      #1 chk("R3 upper reads zero", bus_rdata, 16'h005A);
      bus_write(2'b11, 16'h1234);
      chk("R3 data field written", bus_rdata, 16'h0034);
      @(negedge clk); chan_en = 1'b0;
      #1 chk("R3 divider kept", bus_rdata, 16'hFE34);
   endtask

   task automatic t_low_lane();
      bus_write(2'b11, 16'hFFFF);
      bus_write(2'b01, 16'h0012);
      chk("R4 low lane clears divider", bus_rdata, 16'h0112);
      bus_write(2'b10, 16'hAB00);
      chk("R2 high lane after clear", bus_rdata, 16'hAB12);
   endtask

   task automatic t_rx_priority();
      bus_write(2'b11, 16'h4C00);
      @(negedge clk); chan_en = 1'b1;
      @(negedge clk);
      bus_wr = 1'b1; bus_be = 2'b11; bus_wdata = 16'hFFAA;
      rx_load = 1'b1; rx_data = 9'h155;
      @(negedge clk);
      bus_wr = 1'b0; bus_be = 2'b00; rx_load = 1'b0;
      chk("R5 rx wins on read", bus_rdata, 16'h0155);
      chk("R5 tx tap", tx_data, 9'h155);
      @(negedge clk); rx_data = 9'h0A3; rx_load = 1'b1;
      @(negedge clk); rx_load = 1'b0;
      chk("R5 rx load alone", tx_data, 9'h0A3);
      chan_en = 1'b0;
      #1 chk("R5 divider untouched", bus_rdata, 16'h4CA3);
   endtask

   task automatic t_divider(input int n);
      int j = 0;
      int k = 0;
      ext_clk_sel = 1'b0; chan_en = 1'b0;
      bus_write(2'b11, 16'(n << 9));
      @(negedge clk); chan_en = 1'b1;
      do begin @(negedge clk); j++; end while (!xfer_tick && j < 600);
      chk($sformatf("R6 first tick N=%0d", n), j, 2*n + 1);
      do begin @(negedge clk); k++; end while (!xfer_tick && k < 600);
      chk($sformatf("R6 period N=%0d", n), k, 2*(n + 1));
      chan_en = 1'b0;
   endtask

   task automatic t_restart();
      int j = 0;
      bus_write(2'b11, 16'(3 << 9));
      @(negedge clk); chan_en = 1'b1;
      repeat (4) @(negedge clk);
      chan_en = 1'b0;
      @(negedge clk); chan_en = 1'b1;
      do begin @(negedge clk); j++; end while (!xfer_tick && j < 600);
      chk("R7 phase restart", j, 7);
      chan_en = 1'b0;
   endtask

   task automatic t_ext_clock();
      int pulses = 0;
      int pos = 0;
      int first_pos = -1;
      bus_write(2'b11, 16'h0000);
      ext_clk_sel = 1'b1; ext_sclk = 1'b0;
      @(negedge clk); chan_en = 1'b1;
      repeat (4) @(negedge clk);
      for (int e = 0; e < 3; e++) begin
         ext_sclk = 1'b1; pos = 0;
         repeat (5) begin
            @(negedge clk); pos++;
            if (xfer_tick) begin
               pulses++;
               if (first_pos < 0) first_pos = pos;
            end
         end
         ext_sclk = 1'b0;
         repeat (5) begin
            @(negedge clk);
            if (xfer_tick) pulses++;
         end
      end
      chk("R8 one pulse per rise", pulses, 3);
      chk("R8 sync latency", first_pos, 2);
      chan_en = 1'b0; ext_clk_sel = 1'b0;
   endtask

   task automatic t_cfg_err();
      ext_clk_sel = 1'b0; uart_mode = 1'b1;
      bus_write(2'b11, 16'h0200);
      chk("R9 stopped no error", cfg_err, 0);
      @(negedge clk); chan_en = 1'b1;
      #1 chk("R9 divider 1 in uart", cfg_err, 1);
      uart_mode = 1'b0;
      #1 chk("R9 sync framing ok", cfg_err, 0);
      ext_clk_sel = 1'b1; uart_mode = 1'b1;
      #1 chk("R9 external clock no error", cfg_err, 0);
      ext_clk_sel = 1'b0;
      @(negedge clk); chan_en = 1'b0;
      bus_write(2'b11, 16'h0400);
      @(negedge clk); chan_en = 1'b1;
      #1 chk("R9 divider 2 legal", cfg_err, 0);
      @(negedge clk); chan_en = 1'b0;
      bus_write(2'b11, 16'h0000);
      @(negedge clk); chan_en = 1'b1;
      #1 chk("R9 divider 0 in uart", cfg_err, 1);
      @(negedge clk); chan_en = 1'b0; uart_mode = 1'b0;
   endtask

   task automatic t_quiet();
      int seen = 0;
      chan_en = 1'b0; ext_clk_sel = 1'b0;
      repeat (20) begin @(negedge clk); if (xfer_tick) seen++; end
      ext_clk_sel = 1'b1;
      for (int e = 0; e < 4; e++) begin
         ext_sclk = ~ext_sclk;
         repeat (4) begin @(negedge clk); if (xfer_tick) seen++; end
      end
      chk("R10 no tick while stopped", seen, 0);
      ext_clk_sel = 1'b0; ext_sclk = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_full_write();
      t_enabled_write();
      t_low_lane();
      t_rx_priority();
      t_divider(0);
      t_divider(1);
      t_divider(5);
      t_divider(127);
      t_restart();
      t_ext_clock();
      t_cfg_err();
      t_quiet();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_checks++; n_errs++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
         $finish;
      end
   end
endmodule